// File: doc/BRIEF.md
# Programmable Square-Wave Generator

This block produces a selectable square wave from a 32.768 kHz reference clock. An 8-bit control byte picks what the output pin does. When the enable bit is set, the output is one of four rates taken from a binary divider chain clocked by the reference. When the enable bit is clear, the output is driven to a static level that software programs.

A clock-halt flag comes from the timekeeping logic. While it is set, the divider stops and the divided output holds its level. The control byte is sampled on each rising reference edge, so a new setting reaches the pin one edge after it is presented. Changing the rate moves the output to a different stage of the same running divider. The divider is not restarted.

Top module: `sqw_gen`

## Requirements
- R1: While reset is asserted, and until the first rising edge after reset is released, the output is low and the divider is cleared.
- R2: Control bit 4 is the enable. When bit 4 is 0, the output equals control bit 7 from the first rising reference edge after the byte is applied.
- R3: With the enable set and rate code bits[1:0] = 00, the output divides the reference by 32768 and is high for 16384 reference cycles and low for 16384.
- R4: With the enable set and rate code 01, the output divides the reference by 8 and is high for 4 cycles and low for 4.
- R5: With the enable set and rate code 10, the output divides the reference by 4 and is high for 2 cycles and low for 2.
- R6: With the enable set and rate code 11, the output follows the reference clock. It is high while the reference is high and low while it is low.
- R7: Control bits 6, 5, 3 and 2 have no effect. Bit 7 has no effect while the enable is set. Bits 1:0 have no effect while the enable is clear.
- R8: While the halt flag is high, the divider does not advance and a divided output keeps its level. At rate 11 the output parks low from the next falling reference edge and resumes after the first falling edge with the flag low.
- R9: A new rate code selects its divider stage at the next rising reference edge. The divider keeps counting through the switch, so the new output is the matching bit of the uninterrupted count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_i | input | 8 | Control byte: bit 7 static level, bit 4 enable, bits 1:0 rate |
| halt_i | input | 1 | Clock-halt flag; stops the divider while high |
| wave_o | output | 1 | Square-wave or static-level output |

## Verification
A static level or a new rate code becomes visible one rising reference edge after it is applied, because the control byte passes through one register. The bench therefore drives inputs in the high half of the clock and samples the output one nanosecond after the next rising edge. Divided rates are checked by counting high and low samples over full periods after a settling edge. The rate-switch test locks a model count to an observed edge of the divide-by-8 stage and then predicts every following cycle. The full-rate path is combinational from the reference clock. It is sampled in both halves of a cycle, and the halt gate is given one falling edge before its effect is checked.

// File: rtl/sqw_pkg.sv
`timescale 1ns/1ps
package sqw_pkg;

  localparam int CTRL_W    = 8;
  localparam int LEVEL_BIT = 7;
  localparam int EN_BIT    = 4;
  localparam int RATE_LSB  = 0;
  localparam int RATE_W    = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_SLOW = 2'b00,
    RATE_MID  = 2'b01,
    RATE_HIGH = 2'b10,
    RATE_FULL = 2'b11
  } rate_e;

  typedef struct packed {
    logic  level;
    logic  enable;
    rate_e rate;
  } sqw_cfg_t;

  function automatic sqw_cfg_t decode_ctrl(input logic [CTRL_W-1:0] raw);
    sqw_cfg_t c;
    c.level  = raw[LEVEL_BIT];
    c.enable = raw[EN_BIT];
    c.rate   = rate_e'(raw[RATE_LSB +: RATE_W]);
    return c;
  endfunction

endpackage

// File: rtl/sqw_rst_sync.sv
`timescale 1ns/1ps
module sqw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sqw_ctrl_reg.sv
`timescale 1ns/1ps
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  output sqw_cfg_t          cfg_o
);

  sqw_cfg_t cfg_q;
  sqw_cfg_t cfg_d;
  logic     unused_ctrl_bits;

  // Only the decoded fields are stored; the remaining bits fall away here.
  assign unused_ctrl_bits = ^{ctrl_i[6:5], ctrl_i[3:2]};

  always_comb begin
    cfg_d = decode_ctrl(ctrl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/sqw_divider.sv
`timescale 1ns/1ps
module sqw_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [DIV_W-1:0] cnt_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));

  // R3
  chain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/sqw_tap_mux.sv
`timescale 1ns/1ps
module sqw_tap_mux
  import sqw_pkg::*;
#(
  parameter int DIV_W    = 15,
  parameter int TAP_SLOW = 14,
  parameter int TAP_MID  = 2,
  parameter int TAP_HIGH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  sqw_cfg_t         cfg_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic             wave_o
);

  logic gate_q;
  logic gate_d;
  logic tapped;
  logic full_rate;
  logic unused_cnt;

  assign unused_cnt = ^cnt_i;

  // The gate enable is updated while the reference is low, so the
  // full-rate output never carries a shortened pulse.
  always_comb begin
    gate_d = !halt_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  always_comb begin
    unique case (cfg_i.rate)
      RATE_SLOW: tapped = cnt_i[TAP_SLOW];
      RATE_MID:  tapped = cnt_i[TAP_MID];
      RATE_HIGH: tapped = cnt_i[TAP_HIGH];
      default:   tapped = 1'b0;
    endcase
    full_rate = clk & gate_q;
    if (!cfg_i.enable)                wave_o = cfg_i.level;
    else if (cfg_i.rate == RATE_FULL) wave_o = full_rate;
    else                              wave_o = tapped;
  end

  // R8
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && cfg_i.enable && cfg_i.rate != RATE_FULL)
      |=> (!$stable(cfg_i) || $stable(wave_o)));

endmodule

// File: rtl/sqw_gen.sv
`timescale 1ns/1ps
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int REF_HZ   = 32768,
  parameter int DIV_MID  = 8,
  parameter int DIV_HIGH = 4,
  parameter int SYNC_STG = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_i,
  input  logic       halt_i,
  output logic       wave_o
);

  localparam int DIV_W    = $clog2(REF_HZ);
  localparam int TAP_SLOW = DIV_W - 1;
  localparam int TAP_MID  = $clog2(DIV_MID) - 1;
  localparam int TAP_HIGH = $clog2(DIV_HIGH) - 1;

  logic             rst_n_int;
  sqw_cfg_t         cfg;
  logic [DIV_W-1:0] cnt;

  sqw_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (ref_clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  sqw_ctrl_reg u_ctrl (
    .clk   (ref_clk),
    .rst_n (rst_n_int),
    .ctrl_i(ctrl_i),
    .cfg_o (cfg)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (ref_clk),
    .rst_n(rst_n_int),
    .run_i(!halt_i),
    .cnt_o(cnt)
  );

  sqw_tap_mux #(
    .DIV_W   (DIV_W),
    .TAP_SLOW(TAP_SLOW),
    .TAP_MID (TAP_MID),
    .TAP_HIGH(TAP_HIGH)
  ) u_mux (
    .clk   (ref_clk),
    .rst_n (rst_n_int),
    .halt_i(halt_i),
    .cfg_i (cfg),
    .cnt_i (cnt),
    .wave_o(wave_o)
  );

  // R2
  static_level_chk: assert property (@(posedge ref_clk) disable iff (!rst_n_int)
    !ctrl_i[EN_BIT] |=> (wave_o == $past(ctrl_i[LEVEL_BIT])));

endmodule

// File: tb/sqw_gen_tb.sv
`timescale 1ns/1ps
module sqw_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] ctrl;
  logic       halt;
  logic       wave;

  int n_checks = 0;
  int n_fails  = 0;

  // {kind[1:0], ctrl[7:0], value[15:0]}; kind 0 static, 1 period, 2 full rate
  localparam logic [25:0] VEC [0:8] = '{
    {2'd1, 8'h10, 16'd16384},  // R3
    {2'd1, 8'h11, 16'd4},      // R4
    {2'd1, 8'h12, 16'd2},      // R5
    {2'd2, 8'h13, 16'd0},      // R6
    {2'd0, 8'h00, 16'd0},      // R2
    {2'd0, 8'h80, 16'd1},      // R2
    {2'd0, 8'hED, 16'd1},      // R7 rate/unused ignored when disabled
    {2'd1, 8'h7D, 16'd4},      // R7 unused bits ignored
    {2'd1, 8'h92, 16'd2}       // R7 level ignored when enabled
  };

  sqw_gen dut_i (
    .ref_clk(clk),
    .rst_n  (rst_n),
    .ctrl_i (ctrl),
    .halt_i (halt),
    .wave_o (wave)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic measure(input int half, input string req);
    int hi = 0;
    int lo = 0;
    while (wave !== 1'b0) tick();
    while (wave !== 1'b1) tick();
    while (wave === 1'b1) begin hi++; tick(); end
    while (wave === 1'b0) begin lo++; tick(); end
    check(hi == half, {req, " high"}, hi, half);
    check(lo == half, {req, " low"}, lo, half);
  endtask

  initial begin
    #(190000 * 5);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails);
    $finish;
  end

  initial begin
    int m;
    logic w0;
    rst_n = 1'b0;
    ctrl  = 8'h80;
    halt  = 1'b0;
    tick(); tick(); tick();
    check(wave == 1'b0, "R1 reset output", wave, 0);
    #0.5 rst_n = 1'b1;
    tick();
    check(wave == 1'b0, "R1 output after release", wave, 0);
    tick(); tick();

    for (int i = 0; i < 9; i++) begin
      #0.5 ctrl = VEC[i][23:16];
      tick(); tick();
      case (VEC[i][25:24])
        2'd0: begin
          check(wave == VEC[i][0], "R2/R7 static level", wave, VEC[i][0]);
          tick(); tick();
          check(wave == VEC[i][0], "R2/R7 static hold", wave, VEC[i][0]);
        end
        2'd1: measure(VEC[i][15:0], "R3/R4/R5/R7 period");
        default: begin
          for (int k = 0; k < 3; k++) begin
            check(wave == 1'b1, "R6 ref high phase", wave, 1);
            #2.5;
            check(wave == 1'b0, "R6 ref low phase", wave, 0);
            tick();
          end
        end
      endcase
    end

    // R2 next-edge timing: level visible exactly one edge after the write
    #0.5 ctrl = 8'h00;
    tick();
    #0.5 ctrl = 8'h80;
    check(wave == 1'b0, "R2 before edge", wave, 0);
    tick();
    check(wave == 1'b1, "R2 after one edge", wave, 1);

    // R9: lock model count to divide-by-8 stage, then switch rates
    #0.5 ctrl = 8'h11;
    tick(); tick();
    while (wave !== 1'b0) tick();
    while (wave !== 1'b1) tick();
    m = 4;
    for (int i = 0; i < 24; i++) begin
      logic [1:0] r;
      logic e;
      r = (((i / 5) % 2) == 1) ? 2'b10 : 2'b01;
      #0.5 ctrl = {6'b000100, r};
      tick();
      m++;
      e = (r == 2'b10) ? m[1] : m[2];
      check(wave == e, "R9 rate switch continuity", wave, e);
    end

    // R8: halt freezes divided output
    #0.5 ctrl = 8'h11;
    tick(); tick(); tick();
    w0 = wave;
    #0.5 halt = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick();
      check(wave == w0, "R8 divided hold", wave, w0);
    end
    #0.5 ctrl = 8'h13;
    tick(); tick();
    check(wave == 1'b0, "R8 full rate parked", wave, 0);
    #0.5 halt = 1'b0;
    tick();
    check(wave == 1'b1, "R8 full rate resumes", wave, 1);

    // R1: reassert reset mid-run
    #0.5 rst_n = 1'b0;
    #0.5;
    check(wave == 1'b0, "R1 async reset", wave, 0);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule